// File: doc/BRIEF.md
# Sync Polarity, Presence and Clamp Conditioner

This block sits between the raw horizontal and vertical sync pins of a display monitor and the rest of the scan logic. Both inputs pass through two-flop synchronisers. For each one, the block measures which logic level is the short active pulse and reports that level as a polarity bit. It also flags the input as absent when the input stops toggling. Every downstream function works on an active-high copy of each sync, so it does not depend on how the video source drives its pins.

The block drives two sync outputs. Each one is the normalised sync re-driven at a polarity chosen by a control bit. When composite sync arrives on the horizontal pin, a separator can be switched in. The separator recovers vertical sync from the broad pulses, and the vertical output then follows the separator. A clamp pulse generator fires on a chosen edge of the normalised horizontal sync. Its pulse length is chosen from four settings.

Top module: `sync_cond_top`

## Requirements
- R1: Status bit 0 (horizontal) and bit 1 (vertical) show the input polarity, with 0 = positive and 1 = negative. Each bit is updated once per window of WIN clocks. It becomes 1 when the synchronised input was high on more than WIN/2 of those clocks, and otherwise 0.
- R2: `hout` equals the active-high horizontal sync XOR `cfg_hout_neg`. It follows the pin three clocks later.
- R3: Status bit 2 (horizontal) and bit 3 (vertical) are set when the input has shown no edge for the timeout period (H_TIMEOUT or V_TIMEOUT clocks). Each bit clears on the next edge of its input.
- R4: The clamp pulse starts on the leading (active-going) edge of the normalised horizontal sync when `cfg_clamp_trail` is 0, and on the trailing edge when it is 1.
- R5: `cfg_clamp_wsel` codes 0, 1, 2 and 3 give clamp pulses of 8, 16, 32 and 64 clocks (CLAMP_BASE shifted left by the code).
- R6: A trigger edge that arrives while a clamp pulse is running is ignored. It neither restarts nor extends the pulse.
- R7: With `cfg_vsep_en` = 0, `vout` equals the active-high vertical sync XOR `cfg_vout_neg`.
- R8: With `cfg_vsep_en` = 1, `vout` is driven from the horizontal pin. It goes active only after an active pulse on that pin has lasted VSEP_THR clocks, and it stays inactive during ordinary line pulses.
- R9: While reset is held, the status reads 0 and `hout`, `vout` and `clamp_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal or composite sync pin |
| vsync_in | input | 1 | Raw vertical sync pin |
| cfg_vsep_en | input | 1 | 1 selects the composite separator as the vertical source |
| cfg_hout_neg | input | 1 | Polarity of hout: 0 positive, 1 negative |
| cfg_vout_neg | input | 1 | Polarity of vout: 0 positive, 1 negative |
| cfg_clamp_trail | input | 1 | Clamp trigger edge: 0 leading, 1 trailing |
| cfg_clamp_wsel | input | 2 | Clamp width code |
| sync_status | output | 4 | {v_missing, h_missing, v_neg, h_neg} |
| hout | output | 1 | Regenerated horizontal sync |
| vout | output | 1 | Regenerated vertical sync |
| clamp_out | output | 1 | Horizontal clamp pulse |

## Verification
A wrong polarity decision inverts `hout` and moves the clamp to the opposite edge. It shows up at the end of the next measurement window plus three clocks. A stuck idle counter shows as a missing flag that never rises, or never falls, within a few clocks of the timeout or of the next edge. A clamp counter that reloads on a second edge gives a pulse longer than the selected width. The separator counter is checked by whether `vout` stays quiet through line pulses and rises part-way through a broad pulse.

// File: rtl/sync_pkg.sv
package sync_pkg;

    // per-channel result of the measurement unit
    typedef struct packed {
        logic pol_neg;
        logic missing;
        logic act;
    } chan_t;

    // software-visible status word, bit 0 first from the right
    typedef struct packed {
        logic v_missing;
        logic h_missing;
        logic v_neg;
        logic h_neg;
    } status_t;

    function automatic int clamp_len(input logic [1:0] code, input int base);
        return base << code;
    endfunction

endpackage

// File: rtl/sync_meas.sv
module sync_meas
    import sync_pkg::*;
#(
    parameter int WIN     = 256,
    parameter int TIMEOUT = 100000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output chan_t chan
);
    localparam int WW = $clog2(WIN);
    localparam int HW = $clog2(WIN + 1);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic          s1, s2, s2_d;
    logic [WW-1:0] wcnt;
    logic [HW-1:0] hcnt;
    logic [HW-1:0] total;
    logic [TW-1:0] idle;
    logic          pol_q, miss_q;
    logic          win_end, edge_seen;

    assign win_end   = (wcnt == WW'(WIN - 1));
    assign total     = hcnt + HW'(s2);
    assign edge_seen = s2 ^ s2_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            s2_d   <= 1'b0;
            wcnt   <= '0;
            hcnt   <= '0;
            pol_q  <= 1'b0;
            idle   <= '0;
            miss_q <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            s2_d <= s2;
            if (win_end) begin
                wcnt  <= '0;
                hcnt  <= '0;
                pol_q <= (total > HW'(WIN / 2));
            end else begin
                wcnt <= wcnt + 1'b1;
                hcnt <= total;
            end
            if (edge_seen) begin
                idle   <= '0;
                miss_q <= 1'b0;
            end else if (idle == TW'(TIMEOUT - 1)) begin
                miss_q <= 1'b1;
            end else begin
                idle <= idle + 1'b1;
            end
        end
    end

    assign chan.pol_neg = pol_q;
    assign chan.missing = miss_q;
    assign chan.act     = s2 ^ pol_q;

    // R1
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(pol_q));

    // R3
    miss_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_q) |-> $past(!edge_seen));

endmodule

// File: rtl/vsep_unit.sv
module vsep_unit #(
    parameter int THR = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic act,
    output logic sep
);
    localparam int CW = $clog2(THR + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            cnt <= '0;
            sep <= 1'b0;
        end else begin
            if (cnt != CW'(THR))
                cnt <= cnt + 1'b1;
            sep <= (cnt == CW'(THR));
        end
    end

endmodule

// File: rtl/clamp_gen.sv
module clamp_gen
    import sync_pkg::*;
#(
    parameter int BASE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  logic       trail,
    input  logic [1:0] wsel,
    output logic       pulse
);
    localparam int MAXW = BASE << 3;
    localparam int CW   = $clog2(MAXW);

    logic          act_d, busy, trig;
    logic [CW-1:0] cnt;

    assign trig = trail ? (act_d & ~act) : (act & ~act_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d <= 1'b0;
            busy  <= 1'b0;
            cnt   <= '0;
        end else begin
            act_d <= act;
            if (busy) begin
                if (cnt == '0)
                    busy <= 1'b0;
                else
                    cnt <= cnt - 1'b1;
            end else if (trig) begin
                busy <= 1'b1;
                cnt  <= CW'(clamp_len(wsel, BASE) - 1);
            end
        end
    end

    assign pulse = busy;

    // R4
    clamp_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig));

    // R6
    clamp_noretrig_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sync_cond_top.sv
module sync_cond_top
    import sync_pkg::*;
#(
    parameter int WIN        = 256,
    parameter int H_TIMEOUT  = 100000,
    parameter int V_TIMEOUT  = 6500000,
    parameter int VSEP_THR   = 24,
    parameter int CLAMP_BASE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       vsync_in,
    input  logic       cfg_vsep_en,
    input  logic       cfg_hout_neg,
    input  logic       cfg_vout_neg,
    input  logic       cfg_clamp_trail,
    input  logic [1:0] cfg_clamp_wsel,
    output logic [3:0] sync_status,
    output logic       hout,
    output logic       vout,
    output logic       clamp_out
);
    localparam int NCH = 2;

    logic [NCH-1:0] pins;
    chan_t          ch [NCH];
    logic           sep, vsrc;
    status_t        st;

    assign pins = {vsync_in, hsync_in};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int TO = (i == 0) ? H_TIMEOUT : V_TIMEOUT;
        sync_meas #(.WIN(WIN), .TIMEOUT(TO)) u_meas (
            .clk (clk),
            .rst (rst),
            .pin (pins[i]),
            .chan(ch[i])
        );
    end

    vsep_unit #(.THR(VSEP_THR)) u_vsep (
        .clk(clk),
        .rst(rst),
        .act(ch[0].act),
        .sep(sep)
    );

    clamp_gen #(.BASE(CLAMP_BASE)) u_clamp (
        .clk  (clk),
        .rst  (rst),
        .act  (ch[0].act),
        .trail(cfg_clamp_trail),
        .wsel (cfg_clamp_wsel),
        .pulse(clamp_out)
    );

    assign vsrc = cfg_vsep_en ? sep : ch[1].act;

    always_ff @(posedge clk) begin
        if (rst) begin
            hout <= 1'b0;
            vout <= 1'b0;
        end else begin
            hout <= ch[0].act ^ cfg_hout_neg;
            vout <= vsrc ^ cfg_vout_neg;
        end
    end

    assign st.h_neg     = ch[0].pol_neg;
    assign st.v_neg     = ch[1].pol_neg;
    assign st.h_missing = ch[0].missing;
    assign st.v_missing = ch[1].missing;
    assign sync_status  = st;

endmodule

// File: tb/tb_sync_cond_top.sv
module tb_sync_cond_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0, vsync_in = 1'b0;
    logic       cfg_vsep_en = 1'b0, cfg_hout_neg = 1'b0, cfg_vout_neg = 1'b0;
    logic       cfg_clamp_trail = 1'b0;
    logic [1:0] cfg_clamp_wsel = 2'd0;
    logic [3:0] sync_status;
    logic       hout, vout, clamp_out;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    sync_cond_top #(.WIN(256), .H_TIMEOUT(300), .V_TIMEOUT(500),
                    .VSEP_THR(24), .CLAMP_BASE(8)) dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .cfg_vsep_en(cfg_vsep_en), .cfg_hout_neg(cfg_hout_neg),
        .cfg_vout_neg(cfg_vout_neg), .cfg_clamp_trail(cfg_clamp_trail),
        .cfg_clamp_wsel(cfg_clamp_wsel), .sync_status(sync_status),
        .hout(hout), .vout(vout), .clamp_out(clamp_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic h_pattern(input int n, input int per, input int alen, input bit lvl);
        for (int p = 0; p < n; p++)
            for (int j = 0; j < per; j++) begin
                @(negedge clk);
                hsync_in = (j < alen) ? lvl : ~lvl;
            end
    endtask

    task automatic v_pattern(input int n, input int per, input int alen, input bit lvl);
        for (int p = 0; p < n; p++)
            for (int j = 0; j < per; j++) begin
                @(negedge clk);
                vsync_in = (j < alen) ? lvl : ~lvl;
            end
    endtask

    // R9
    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(sync_status == 4'h0, "R9 status", sync_status, 0);
        chk({hout, vout, clamp_out} == 3'b000, "R9 outputs", {hout, vout, clamp_out}, 0);
        rst = 1'b0;
    endtask

    // R1
    task automatic t_polarity();
        h_pattern(40, 16, 4, 1'b0);
        chk(sync_status[0] == 1'b1, "R1 h negative", sync_status[0], 1);
        h_pattern(40, 16, 4, 1'b1);
        chk(sync_status[0] == 1'b0, "R1 h positive", sync_status[0], 0);
        v_pattern(40, 16, 4, 1'b0);
        chk(sync_status[1] == 1'b1, "R1 v negative", sync_status[1], 1);
        v_pattern(40, 16, 4, 1'b1);
        chk(sync_status[1] == 1'b0, "R1 v positive", sync_status[1], 0);
    endtask

    // R2
    task automatic t_hout();
        for (int neg = 0; neg < 2; neg++) begin
            cfg_hout_neg = neg[0];
            for (int p = 0; p < 4; p++)
                for (int j = 0; j < 16; j++) begin
                    @(negedge clk);
                    hsync_in = (j < 6);
                    if (p == 3 && j == 5)
                        chk(hout == ~neg[0], "R2 hout active", hout, ~neg[0]);
                    if (p == 3 && j == 12)
                        chk(hout == neg[0], "R2 hout idle", hout, neg[0]);
                end
        end
        cfg_hout_neg = 1'b0;
    endtask

    // R3
    task automatic t_missing();
        @(negedge clk);
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (600) @(negedge clk);
        chk(sync_status[2] == 1'b1, "R3 h missing set", sync_status[2], 1);
        chk(sync_status[3] == 1'b1, "R3 v missing set", sync_status[3], 1);
        hsync_in = 1'b1;
        vsync_in = 1'b1;
        @(negedge clk);
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(sync_status[2] == 1'b0, "R3 h missing clear", sync_status[2], 0);
        chk(sync_status[3] == 1'b0, "R3 v missing clear", sync_status[3], 0);
    endtask

    // R4: positive hsync, 20 active of 100; width 8
    task automatic t_clamp_edge();
        cfg_clamp_wsel  = 2'd0;
        for (int m = 0; m < 2; m++) begin
            cfg_clamp_trail = m[0];
            for (int p = 0; p < 3; p++)
                for (int j = 0; j < 100; j++) begin
                    @(negedge clk);
                    hsync_in = (j < 20);
                    if (p == 2 && j == 6)
                        chk(clamp_out == ~m[0], "R4 clamp at leading", clamp_out, ~m[0]);
                    if (p == 2 && j == 26)
                        chk(clamp_out == m[0], "R4 clamp at trailing", clamp_out, m[0]);
                end
        end
        cfg_clamp_trail = 1'b0;
    endtask

    // R5
    task automatic t_clamp_width();
        for (int c = 0; c < 4; c++) begin
            int cnt = 0;
            cfg_clamp_wsel = c[1:0];
            h_pattern(1, 100, 20, 1'b1);
            for (int j = 0; j < 100; j++) begin
                @(negedge clk);
                hsync_in = (j < 20);
                cnt += int'(clamp_out);
            end
            chk(cnt == (8 << c), "R5 clamp width", cnt, 8 << c);
        end
    endtask

    // R6
    task automatic t_clamp_retrig();
        int cnt = 0;
        cfg_clamp_wsel = 2'd1;
        h_pattern(1, 100, 0, 1'b1);
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            hsync_in = (j < 3) || (j >= 10 && j < 13);
            cnt += int'(clamp_out);
        end
        chk(cnt == 16, "R6 retrigger ignored", cnt, 16);
    endtask

    // R7
    task automatic t_vout_direct();
        cfg_vsep_en = 1'b0;
        v_pattern(40, 16, 6, 1'b1);
        for (int neg = 0; neg < 2; neg++) begin
            cfg_vout_neg = neg[0];
            for (int p = 0; p < 2; p++)
                for (int j = 0; j < 16; j++) begin
                    @(negedge clk);
                    vsync_in = (j < 6);
                    if (p == 1 && j == 5)
                        chk(vout == ~neg[0], "R7 vout active", vout, ~neg[0]);
                    if (p == 1 && j == 12)
                        chk(vout == neg[0], "R7 vout idle", vout, neg[0]);
                end
        end
        cfg_vout_neg = 1'b0;
    endtask

    // R8
    task automatic t_vsep();
        int cnt = 0;
        cfg_vsep_en  = 1'b1;
        cfg_vout_neg = 1'b0;
        for (int j = 0; j < 300; j++) begin
            @(negedge clk);
            hsync_in = ((j % 30) < 6);
            cnt += int'(vout);
        end
        chk(cnt == 0, "R8 no vsync on line pulses", cnt, 0);
        for (int j = 0; j < 70; j++) begin
            @(negedge clk);
            hsync_in = (j < 40);
            if (j == 10) chk(vout == 1'b0, "R8 early broad", vout, 0);
            if (j == 35) chk(vout == 1'b1, "R8 broad detected", vout, 1);
            if (j == 50) chk(vout == 1'b0, "R8 after broad", vout, 0);
        end
        cfg_vout_neg = 1'b1;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            hsync_in = 1'b1;
            if (j == 35) chk(vout == 1'b0, "R8 broad inverted", vout, 0);
        end
        cfg_vout_neg = 1'b0;
        cfg_vsep_en  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_polarity();
        t_hout();
        t_missing();
        t_clamp_edge();
        t_clamp_width();
        t_clamp_retrig();
        t_vout_direct();
        t_vsep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule